// File: doc/BRIEF.md
# Predicated Vector Gather Load Sequencer

This block carries out one masked gather of 64-bit elements into a vector register. A start pulse captures four things:
- a vector of per-lane base addresses,
- a scalar offset, together with the index of the general register it came from,
- a bank of eight predicate registers, with a selector that picks one of them,
- a tag-check enable.

The block then walks the lanes from lowest to highest. For each lane that the chosen predicate enables, it sends a single 8-byte read request over a valid/ready memory port. Each request is marked as a streaming, non-temporal access.

Lanes that are switched off produce zeros and cause no memory traffic. The gathered vector becomes visible on the result output only after the last lane completes, and a one-cycle done pulse marks that moment. If any response comes back with an error, the operation stops: a fault pulse is raised and the result is left untouched.

Top module: `gather_ld_seq`

## Requirements
- R1: The request address for lane e is base element e (bits 64e+63..64e of base_vec), zero-extended, plus the 64-bit offset. The offset is not scaled and the sum wraps modulo 2^64.
- R2: When scalar_idx equals 31, the offset is zero whatever scalar_val holds. For any other index, the offset is scalar_val.
- R3: Lane e is active when bit 8e of the selected predicate is 1. An inactive lane issues no request and reads as zero in the result. Every other predicate bit is ignored.
- R4: pred_sel is 3 bits wide and selects predicate p = pred_bank[p*VLEN/8 +: VLEN/8].
- R5: Every request shows req_size = 8 (bytes) and req_stream = 1.
- R6: req_tagchk equals the tag_en value captured at start.
- R7: Active lanes are requested in ascending lane order. At most one request is outstanding at a time. A request that is not yet accepted holds req_valid and req_addr steady.
- R8: Returned rsp_data is placed unchanged (unsigned, no extension) into the lane that requested it.
- R9: result changes only in the same cycle that done pulses high. done lasts one cycle.
- R10: A response with rsp_err = 1 ends the operation. fault pulses for one cycle, done does not pulse, and result keeps its previous value.
- R11: With no active lanes, done rises on the second clock edge after start is sampled, and result becomes all zeros.
- R12: start is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| base_vec | input | VLEN | Per-lane base addresses, lane e at bits 64e+63..64e |
| scalar_val | input | 64 | Value of the offset register |
| scalar_idx | input | 5 | Index of the offset register; 31 means zero offset |
| pred_bank | input | 8*VLEN/8 | Eight predicate registers, concatenated |
| pred_sel | input | 3 | Governing predicate selector |
| tag_en | input | 1 | Memory tagging enabled |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Byte address of the read |
| req_size | output | 4 | Access size in bytes (always 8) |
| req_stream | output | 1 | Streaming / non-temporal hint |
| req_tagchk | output | 1 | Request is tag-checked |
| rsp_valid | input | 1 | Read response valid |
| rsp_ready | output | 1 | Block accepts a response |
| rsp_data | input | 64 | Returned doubleword |
| rsp_err | input | 1 | Response carries an error |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| fault | output | 1 | One-cycle pulse on an aborted operation |
| result | output | VLEN | Destination vector |

## Verification
The bench builds the block with VLEN = 256. That gives four lanes, a 32-bit predicate per register and a 256-bit bank. At this size, the last lane, lanes skipped in the middle of the walk, and all eight predicate selectors can be reached within short runs. Random memory stall and response delays, injected error lanes, offset wrap-around and the index-31 offset are all exercised, along with a start pulse sent during a busy operation.

// File: rtl/gather_ld_pkg.sv
package gather_ld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_REQ  = 2'd2,
        ST_WAIT = 2'd3
    } gl_state_e;

    localparam int unsigned ELEM_W     = 64;
    localparam int unsigned ADDR_W     = 64;
    localparam int unsigned NPRED      = 8;
    localparam int unsigned ZERO_REG   = 31;
    localparam logic [3:0]  ACC_BYTES  = 4'd8;

endpackage

// File: rtl/gather_ld_pred.sv
module gather_ld_pred #(
    parameter int unsigned VLEN  = 256,
    parameter int unsigned NPRED = 8,
    localparam int unsigned LANES = VLEN / 64,
    localparam int unsigned PW    = VLEN / 8,
    localparam int unsigned SEL_W = $clog2(NPRED)
) (
    input  logic [NPRED*PW-1:0] bank,
    input  logic [SEL_W-1:0]    sel,
    output logic [LANES-1:0]    lane_mask
);

    logic [PW-1:0] chosen;
    logic          unused_pred_bits;

    assign chosen = bank[sel*PW +: PW];

    // One governing bit per 64-bit lane: the lowest byte flag of each element.
    for (genvar e = 0; e < LANES; e++) begin : g_lane_bit
        assign lane_mask[e] = chosen[8*e];
    end

    assign unused_pred_bits = ^chosen;

endmodule

// File: rtl/gather_ld_pick.sv
module gather_ld_pick #(
    parameter int unsigned LANES = 4,
    localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] mask,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [LANES-1:0] grant
);

    always_comb begin
        idx = '0;
        for (int e = LANES - 1; e >= 0; e--) begin
            if (mask[e]) begin
                idx = IDX_W'(e);
            end
        end
    end

    assign found = |mask;
    assign grant = mask & ~(mask - LANES'(1));

endmodule

// File: rtl/gather_ld_addr.sv
module gather_ld_addr #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned ELEM_W = 64,
    parameter int unsigned ADDR_W = 64,
    localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES*ELEM_W-1:0] bases,
    input  logic [IDX_W-1:0]        lane,
    input  logic [ADDR_W-1:0]       offset,
    output logic [ADDR_W-1:0]       addr
);

    logic [ELEM_W-1:0] elem;

    always_comb begin
        elem = '0;
        for (int e = 0; e < LANES; e++) begin
            if (IDX_W'(e) == lane) begin
                elem = bases[e*ELEM_W +: ELEM_W];
            end
        end
    end

    assign addr = ADDR_W'(elem) + offset;

endmodule

// File: rtl/gather_ld_seq.sv
module gather_ld_seq
    import gather_ld_pkg::*;
#(
    parameter int unsigned VLEN = 256,
    localparam int unsigned LANES = VLEN / ELEM_W,
    localparam int unsigned PW    = VLEN / 8,
    localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [VLEN-1:0]     base_vec,
    input  logic [63:0]         scalar_val,
    input  logic [4:0]          scalar_idx,
    input  logic [NPRED*PW-1:0] pred_bank,
    input  logic [2:0]          pred_sel,
    input  logic                tag_en,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [63:0]         req_addr,
    output logic [3:0]          req_size,
    output logic                req_stream,
    output logic                req_tagchk,
    input  logic                rsp_valid,
    output logic                rsp_ready,
    input  logic [63:0]         rsp_data,
    input  logic                rsp_err,
    output logic                busy,
    output logic                done,
    output logic                fault,
    output logic [VLEN-1:0]     result
);

    typedef struct packed {
        gl_state_e         st;
        logic [VLEN-1:0]   base;
        logic [63:0]       off;
        logic [LANES-1:0]  pend;
        logic [IDX_W-1:0]  lane;
        logic              tagchk;
        logic [VLEN-1:0]   acc;
        logic [VLEN-1:0]   res;
        logic              done;
        logic              fault;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [LANES-1:0] start_mask;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic [LANES-1:0] pick_grant;
    logic [63:0]      lane_addr;
    logic [63:0]      off_resolved;

    gather_ld_pred #(.VLEN(VLEN), .NPRED(NPRED)) u_pred (
        .bank      (pred_bank),
        .sel       (pred_sel),
        .lane_mask (start_mask)
    );

    gather_ld_pick #(.LANES(LANES)) u_pick (
        .mask  (r_q.pend),
        .found (pick_found),
        .idx   (pick_idx),
        .grant (pick_grant)
    );

    gather_ld_addr #(.LANES(LANES), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W)) u_addr (
        .bases  (r_q.base),
        .lane   (r_q.lane),
        .offset (r_q.off),
        .addr   (lane_addr)
    );

    assign off_resolved = (scalar_idx == 5'(ZERO_REG)) ? 64'd0 : scalar_val;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.base   = base_vec;
                    r_d.off    = off_resolved;
                    r_d.pend   = start_mask;
                    r_d.tagchk = tag_en;
                    r_d.acc    = '0;
                    r_d.st     = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (pick_found) begin
                    r_d.lane = pick_idx;
                    r_d.st   = ST_REQ;
                end else begin
                    r_d.res  = r_q.acc;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            ST_REQ: begin
                if (req_ready) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_err) begin
                        r_d.fault = 1'b1;
                        r_d.pend  = '0;
                        r_d.st    = ST_IDLE;
                    end else begin
                        for (int e = 0; e < LANES; e++) begin
                            if (IDX_W'(e) == r_q.lane) begin
                                r_d.acc[e*ELEM_W +: ELEM_W] = rsp_data;
                                r_d.pend[e]                 = 1'b0;
                            end
                        end
                        r_d.st = ST_SCAN;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_valid  = (r_q.st == ST_REQ);
    assign req_addr   = lane_addr;
    assign req_size   = ACC_BYTES;
    assign req_stream = 1'b1;
    assign req_tagchk = r_q.tagchk;
    assign rsp_ready  = (r_q.st == ST_WAIT);
    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign fault      = r_q.fault;
    assign result     = r_q.res;

    // R7: pending request is held until accepted
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    // R7: one outstanding request, never a request while a response is awaited
    a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_ready && !req_valid);

    // R7: the chosen lane is the lowest pending one
    a_r7_pick_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SCAN) && pick_found |-> $onehot(pick_grant) && pick_grant[pick_idx]);

    // R3: a request is only made for a lane still marked active
    a_r3_req_active_lane: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> r_q.pend[r_q.lane]);

    // R5: access shape
    a_r5_req_shape: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_size == 4'd8) && req_stream);

    // R9: result moves only with done
    a_r9_result_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done and fault never coincide
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R12: captured operands do not change while busy
    a_r12_hold_operands: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(r_q.base) && $stable(r_q.off));

endmodule

// File: tb/gather_ld_seq_bench.sv
`timescale 1ns/1ps
module gather_ld_seq_bench;

    localparam int VLEN  = 256;
    localparam int LANES = VLEN / 64;
    localparam int PW    = VLEN / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [VLEN-1:0]   base_vec = '0;
    logic [63:0]       scalar_val = '0;
    logic [4:0]        scalar_idx = '0;
    logic [8*PW-1:0]   pred_bank = '0;
    logic [2:0]        pred_sel = '0;
    logic              tag_en = 1'b0;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [63:0]       req_addr;
    logic [3:0]        req_size;
    logic              req_stream;
    logic              req_tagchk;
    logic              rsp_valid = 1'b0;
    logic              rsp_ready;
    logic [63:0]       rsp_data = '0;
    logic              rsp_err = 1'b0;
    logic              busy;
    logic              done;
    logic              fault;
    logic [VLEN-1:0]   result;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    gather_ld_seq #(.VLEN(VLEN)) u_gather_ld_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base_vec(base_vec),
        .scalar_val(scalar_val), .scalar_idx(scalar_idx), .pred_bank(pred_bank),
        .pred_sel(pred_sel), .tag_en(tag_en), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
        .req_stream(req_stream), .req_tagchk(req_tagchk), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .busy(busy), .done(done), .fault(fault), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        return {a[31:0] ^ 32'h5A3C_96E1, ~a[63:32]} + 64'h0123_4567_89AB_CDEF;
    endfunction

    function automatic logic [63:0] eff_off(input logic [63:0] v, input logic [4:0] i);
        return (i == 5'd31) ? 64'd0 : v;
    endfunction

    function automatic bit lane_on(input logic [8*PW-1:0] bank, input logic [2:0] ps,
                                   input int e);
        return bank[int'(ps)*PW + 8*e];
    endfunction

    // err_k: ordinal of the active lane whose response carries an error (-1: none)
    task automatic run_op(input logic [VLEN-1:0] b, input logic [63:0] xv,
                          input logic [4:0] xi, input logic [8*PW-1:0] bank,
                          input logic [2:0] ps, input logic te, input int err_k,
                          input bit poke, input bit want_fast, input string tag);
        logic [63:0]     addrs[LANES];
        int              nact = 0;
        logic [VLEN-1:0] exp_res = '0;
        logic [VLEN-1:0] old_res;
        int              k = 0;
        int              ph = 0;
        int              cyc = 0;
        bit              seen = 0;
        bit              got_done = 0;
        bit              got_fault = 0;
        bit              overlap = 0;
        bit              poked = 0;
        bit              early_change = 0;

        for (int e = 0; e < LANES; e++) begin
            if (lane_on(bank, ps, e)) begin
                addrs[nact] = b[e*64 +: 64] + eff_off(xv, xi);
                exp_res[e*64 +: 64] = mem_word(addrs[nact]);
                nact++;
            end
        end
        old_res = result;

        @(negedge clk);
        base_vec = b; scalar_val = xv; scalar_idx = xi;
        pred_bank = bank; pred_sel = ps; tag_en = te; start = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (rsp_valid) begin rsp_valid = 1'b0; rsp_err = 1'b0; end
            if (req_ready) req_ready = 1'b0;
            if (done) got_done = 1;
            if (fault) got_fault = 1;
            if (!done && result != old_res) early_change = 1;
            if (done || fault) break;
            if (cyc > 400) begin
                chk(0, {tag, " R7 operation hung"}, VLEN'(cyc), '0);
                break;
            end
            if (ph == 0 && req_valid) begin
                if (!seen) begin
                    seen = 1;
                    if (k >= nact) begin
                        chk(0, {tag, " R3 request for inactive lane"}, VLEN'(req_addr), '0);
                    end else begin
                        chk(req_addr == addrs[k], {tag, " R1/R7 lane address and order"},
                            VLEN'(req_addr), VLEN'(addrs[k]));
                    end
                    chk(req_size == 4'd8 && req_stream == 1'b1, {tag, " R5 size/stream"},
                        VLEN'({req_size, req_stream}), VLEN'({4'd8, 1'b1}));
                    chk(req_tagchk == te, {tag, " R6 tag check flag"},
                        VLEN'(req_tagchk), VLEN'(te));
                    if (poke && !poked) begin
                        poked = 1;
                        base_vec = ~b; scalar_val = ~xv; start = 1'b1;
                    end
                end
                if ($urandom % 2 == 0) begin
                    req_ready = 1'b1; ph = 1; seen = 0;
                end
            end else if (ph == 1) begin
                if (req_valid) overlap = 1;
                if (rsp_ready && ($urandom % 2 == 0)) begin
                    rsp_valid = 1'b1;
                    rsp_data  = (k < nact) ? mem_word(addrs[k]) : 64'd0;
                    rsp_err   = (k == err_k);
                    k++; ph = 0;
                end
            end
        end

        chk(!overlap, {tag, " R7 one outstanding request"}, VLEN'(overlap), '0);
        chk(!early_change, {tag, " R9 result moved without done"}, result, old_res);
        if (err_k >= 0 && err_k < nact) begin
            chk(got_fault && !got_done, {tag, " R10 fault without done"},
                VLEN'({got_fault, got_done}), VLEN'(2'b10));
            chk(result == old_res, {tag, " R10 result kept on abort"}, result, old_res);
        end else begin
            chk(got_done && !got_fault, {tag, " R9 done pulse"},
                VLEN'({got_done, got_fault}), VLEN'(2'b10));
            chk(result == exp_res, {tag, " R8/R3 gathered result"}, result, exp_res);
            chk(k == nact, {tag, " R3 request count"}, VLEN'(k), VLEN'(nact));
            if (want_fast)
                chk(cyc == 2, {tag, " R11 empty predicate latency"}, VLEN'(cyc), VLEN'(2));
        end
        @(negedge clk);
        chk(!done && !fault, {tag, " R9 single-cycle pulse"},
            VLEN'({done, fault}), '0);
    endtask

    function automatic logic [VLEN-1:0] rnd_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [8*PW-1:0] rnd_bank();
        logic [8*PW-1:0] v;
        for (int i = 0; i < 8 * PW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // bank with only predicate ps set, lane bits from m, all non-lane bits of ps set
    function automatic logic [8*PW-1:0] make_bank(input logic [2:0] ps, input logic [LANES-1:0] m,
                                                 input bit junk);
        logic [8*PW-1:0] v = junk ? rnd_bank() : '0;
        logic [PW-1:0]   p = junk ? '1 : '0;
        for (int e = 0; e < LANES; e++) p[8*e] = m[e];
        v[int'(ps)*PW +: PW] = p;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !req_valid && !rsp_ready, "R9 reset outputs idle",
            VLEN'({busy, done, fault, req_valid, rsp_ready}), '0);
        chk(result == '0, "R9 reset result", result, '0);
        rst_n = 1'b1;

        b = {64'h4000, 64'h3000, 64'h2000, 64'h1000};
        run_op(b, 64'h10, 5'd4, make_bank(3'd0, 4'b1111, 0), 3'd0, 1'b0, -1, 0, 0, "dense R8");
        run_op(b, 64'hDEAD_0000, 5'd31, make_bank(3'd2, 4'b1111, 0), 3'd2, 1'b1, -1, 0, 0,
               "zero-reg R2 R6");
        run_op(rnd_vec(), 64'h55, 5'd1, make_bank(3'd6, 4'b0000, 1), 3'd6, 1'b0, -1, 0, 1,
               "empty R11");
        run_op(rnd_vec(), 64'h8, 5'd9, make_bank(3'd5, 4'b1010, 1), 3'd5, 1'b1, -1, 0, 0,
               "sparse R3 R4");
        run_op(rnd_vec(), 64'h8, 5'd9, make_bank(3'd7, 4'b1000, 1), 3'd7, 1'b0, -1, 0, 0,
               "last-lane R3 R4");
        b = {64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
        run_op(b, 64'h20, 5'd0, make_bank(3'd1, 4'b1111, 0), 3'd1, 1'b0, -1, 0, 0, "wrap R1");
        run_op(rnd_vec(), 64'h100, 5'd3, make_bank(3'd4, 4'b1111, 0), 3'd4, 1'b0, 2, 0, 0,
               "error R10");
        run_op(rnd_vec(), 64'h100, 5'd3, make_bank(3'd3, 4'b0110, 0), 3'd3, 1'b1, 0, 0, 0,
               "error-first R10");
        run_op(rnd_vec(), 64'h40, 5'd2, make_bank(3'd0, 4'b1101, 0), 3'd0, 1'b0, -1, 1, 0,
               "restart R12");

        for (int i = 0; i < 30; i++) begin
            logic [2:0] ps = 3'($urandom);
            logic [4:0] xi = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom);
            int         ek = ($urandom % 5 == 0) ? int'($urandom % 4) : -1;
            run_op(rnd_vec(), {$urandom, $urandom}, xi, rnd_bank(), ps, 1'($urandom), ek,
                   ($urandom % 6 == 0), 0, "random R1 R3 R8");
        end

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule